// File: doc/BRIEF.md
# Banked CPU Register File

This block is the register storage of a 16-bit CPU core. It keeps two complete banks of general registers (four data registers, two address registers and a frame-base register per bank). It also keeps a set of registers shared by both banks: a static-base register, two stack pointers, a 20-bit vector-table base and a 20-bit program counter. Two read ports and one write port reach these registers through a small register code and an access-size field. A byte access reaches one half of the first two data registers. A word access reaches any single register. A long access reaches a 32-bit pair of registers.

Two select inputs steer every access. The bank-select input picks which bank the general register codes reach. The stack-select input picks which physical stack pointer the single stack-pointer code reaches. Both inputs are registered inside the block, so a change applies to accesses one cycle later. No contents move between banks. Read data is registered. A read presented in a cycle shows the register state from before that cycle's write, and appears on the output at the next clock edge.

Top module: `banked_regfile`

## Requirements
- R1: A cycle with `rst` high clears every register and both read outputs to zero, and selects bank 0 and the interrupt stack pointer.
- R2: Word size (size code 1) maps register code 0..3 to data registers D0..D3, 4..5 to address registers X0..X1 and 6 to the frame base, all in the active bank; code 7 is the static base and code 8 is the active stack pointer. A word write stores bits 15:0, and a word read returns the register zero-extended to 32 bits.
- R3: Byte size (size code 0) maps codes 0/1 to the low/high half of D0 and codes 2/3 to the low/high half of D1. A byte write stores bits 7:0 into that half and leaves the other half unchanged, and a byte read returns the half zero-extended.
- R4: Long size (size code 2) maps code 0 to D2:D0, code 1 to D3:D1 and code 4 to X1:X0, with the named-first register in bits 31:16. A long write updates both registers at the same clock edge, and a long read returns both from the same state.
- R5: Codes 9 (vector-table base) and 10 (program counter) are 20-bit registers. With word or long size, a write stores bits 19:0 and a read returns bits 19:0 with bits 31:20 zero.
- R6: `bank_sel_i` is sampled each clock. Accesses in the following cycles use bank 0 when the sampled value is 0 and bank 1 when it is 1. The two banks hold independent contents, and switching copies nothing.
- R7: Code 8 reaches the interrupt stack pointer when the sampled `stk_sel_i` is 0 and the user stack pointer when it is 1, from the cycle after the input changes.
- R8: Read data appears on the output one clock after the request. A read of a register written in the same cycle returns the old value, and the new value is visible to a read presented in the next cycle.
- R9: Size code 3, byte size with a code above 3, word or long size with a code above 10, and long size with codes 2, 3 or 5..8 are invalid. An invalid read returns zero, and an invalid write changes no register.
- R10: The two read ports are independent and may address any registers, including the same one, in the same cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| bank_sel_i | input | 1 | Bank select, sampled each cycle |
| stk_sel_i | input | 1 | Stack pointer select, sampled each cycle |
| rd0_code_i | input | CODE_W | Read port 0 register code |
| rd0_size_i | input | 2 | Read port 0 access size |
| rd0_data_o | output | 2*WORD_W | Read port 0 data, registered |
| rd1_code_i | input | CODE_W | Read port 1 register code |
| rd1_size_i | input | 2 | Read port 1 access size |
| rd1_data_o | output | 2*WORD_W | Read port 1 data, registered |
| wr_en_i | input | 1 | Write enable |
| wr_code_i | input | CODE_W | Write register code |
| wr_size_i | input | 2 | Write access size |
| wr_data_i | input | 2*WORD_W | Write data |

## Verification
The bench builds the block with its default parameters: 16-bit registers, 20-bit wide registers and a 4-bit register code. With a 4-bit code, all sixteen codes can be driven, so every invalid code/size pairing is reachable next to the eleven valid ones. With 20-bit wide registers, the zero-extension boundary at bit 20 is distinct from the word boundary at bit 16. Directed sequences toggle the two select inputs in the same cycle as accesses, so the one-cycle select delay is seen. A long random run then compares both read ports against a behavioural model on every clock.

// File: rtl/regfile_pkg.sv
package regfile_pkg;

  // access size field
  localparam logic [1:0] SZ_BYTE = 2'd0;
  localparam logic [1:0] SZ_WORD = 2'd1;
  localparam logic [1:0] SZ_LONG = 2'd2;

  // logical register codes
  localparam int RC_D0   = 0;
  localparam int RC_D1   = 1;
  localparam int RC_X0   = 4;
  localparam int RC_SBR  = 7;
  localparam int RC_STK  = 8;
  localparam int RC_VTB  = 9;
  localparam int RC_PCR  = 10;
  localparam int RC_MAXB = 3;
  localparam int RC_MAXW = 6;

  // physical layout
  localparam int BANKS     = 2;
  localparam int BANK_REGS = 7;
  localparam int IDX_SBR   = BANKS * BANK_REGS;
  localparam int IDX_ISP   = IDX_SBR + 1;
  localparam int IDX_USP   = IDX_SBR + 2;
  localparam int IDX_VTB   = IDX_SBR + 3;
  localparam int IDX_PCR   = IDX_SBR + 4;
  localparam int NPHYS     = IDX_PCR + 1;
  localparam int IDX_W     = $clog2(NPHYS);

  typedef struct packed {
    logic             valid;
    logic             pair;
    logic             half;
    logic             half_hi;
    logic             wide;
    logic [IDX_W-1:0] lo;
    logic [IDX_W-1:0] hi;
  } acc_map_t;

endpackage

// File: rtl/rf_decode.sv
module rf_decode
  import regfile_pkg::*;
#(
  parameter int CODE_W = 4
) (
  input  logic              bank,
  input  logic              stk,
  input  logic [CODE_W-1:0] code,
  input  logic [1:0]        size,
  output acc_map_t          map
);

  logic [IDX_W-1:0] base;
  logic [IDX_W-1:0] code_idx;

  assign base     = bank ? IDX_W'(BANK_REGS) : '0;
  assign code_idx = IDX_W'(code);

  always_comb begin
    map = '0;
    case (size)
      SZ_BYTE: begin
        if (int'(code) <= RC_MAXB) begin
          map.valid   = 1'b1;
          map.half    = 1'b1;
          map.half_hi = code[0];
          map.lo      = base + IDX_W'(code[1]);
        end
      end
      SZ_WORD: begin
        if (int'(code) <= RC_MAXW) begin
          map.valid = 1'b1;
          map.lo    = base + code_idx;
        end else if (int'(code) == RC_SBR) begin
          map.valid = 1'b1;
          map.lo    = IDX_W'(IDX_SBR);
        end else if (int'(code) == RC_STK) begin
          map.valid = 1'b1;
          map.lo    = stk ? IDX_W'(IDX_USP) : IDX_W'(IDX_ISP);
        end else if (int'(code) == RC_VTB || int'(code) == RC_PCR) begin
          map.valid = 1'b1;
          map.wide  = 1'b1;
          map.lo    = (int'(code) == RC_VTB) ? IDX_W'(IDX_VTB) : IDX_W'(IDX_PCR);
        end
      end
      SZ_LONG: begin
        if (int'(code) == RC_D0 || int'(code) == RC_D1 || int'(code) == RC_X0) begin
          map.valid = 1'b1;
          map.pair  = 1'b1;
          map.lo    = base + code_idx;
          map.hi    = base + code_idx + ((int'(code) == RC_X0) ? IDX_W'(1) : IDX_W'(2));
        end else if (int'(code) == RC_VTB || int'(code) == RC_PCR) begin
          map.valid = 1'b1;
          map.wide  = 1'b1;
          map.lo    = (int'(code) == RC_VTB) ? IDX_W'(IDX_VTB) : IDX_W'(IDX_PCR);
        end
      end
      default: map = '0;
    endcase
  end

endmodule

// File: rtl/rf_store.sv
module rf_store
  import regfile_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WIDE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                wr_en,
  input  acc_map_t            map,
  input  logic [2*WORD_W-1:0] wr_data,
  output logic [WIDE_W-1:0]   regs_o [NPHYS]
);

  localparam int HALF_W = WORD_W / 2;
  localparam int PAD_W  = WIDE_W - WORD_W;

  logic [WIDE_W-1:0] regs [NPHYS];

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < NPHYS; i++) regs[i] <= '0;
    end else if (wr_en && map.valid) begin
      if (map.half) begin
        if (map.half_hi) regs[map.lo][WORD_W-1:HALF_W] <= wr_data[HALF_W-1:0];
        else             regs[map.lo][HALF_W-1:0]      <= wr_data[HALF_W-1:0];
      end else if (map.wide) begin
        regs[map.lo] <= wr_data[WIDE_W-1:0];
      end else begin
        regs[map.lo] <= {{PAD_W{1'b0}}, wr_data[WORD_W-1:0]};
      end
      if (map.pair) regs[map.hi] <= {{PAD_W{1'b0}}, wr_data[2*WORD_W-1:WORD_W]};
    end
  end

  assign regs_o = regs;

endmodule

// File: rtl/rf_read_port.sv
module rf_read_port
  import regfile_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WIDE_W = 20
) (
  input  logic                clk,
  input  logic                rst,
  input  acc_map_t            map,
  input  logic [WIDE_W-1:0]   regs [NPHYS],
  output logic [2*WORD_W-1:0] data_q
);

  localparam int OUT_W  = 2 * WORD_W;
  localparam int HALF_W = WORD_W / 2;

  logic [WIDE_W-1:0] lo_val;
  logic [WIDE_W-1:0] hi_val;
  logic [OUT_W-1:0]  data_d;

  assign lo_val = regs[map.lo];
  assign hi_val = regs[map.hi];

  always_comb begin
    if (!map.valid)
      data_d = '0;
    else if (map.pair)
      data_d = {hi_val[WORD_W-1:0], lo_val[WORD_W-1:0]};
    else if (map.half)
      data_d = OUT_W'(map.half_hi ? lo_val[WORD_W-1:HALF_W] : lo_val[HALF_W-1:0]);
    else if (map.wide)
      data_d = OUT_W'(lo_val);
    else
      data_d = OUT_W'(lo_val[WORD_W-1:0]);
  end

  always_ff @(posedge clk) begin
    if (rst) data_q <= '0;
    else     data_q <= data_d;
  end

endmodule

// File: rtl/banked_regfile.sv
module banked_regfile
  import regfile_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WIDE_W = 20,
  parameter int CODE_W = 4
) (
  input  logic                clk,
  input  logic                rst,
  input  logic                bank_sel_i,
  input  logic                stk_sel_i,
  input  logic [CODE_W-1:0]   rd0_code_i,
  input  logic [1:0]          rd0_size_i,
  output logic [2*WORD_W-1:0] rd0_data_o,
  input  logic [CODE_W-1:0]   rd1_code_i,
  input  logic [1:0]          rd1_size_i,
  output logic [2*WORD_W-1:0] rd1_data_o,
  input  logic                wr_en_i,
  input  logic [CODE_W-1:0]   wr_code_i,
  input  logic [1:0]          wr_size_i,
  input  logic [2*WORD_W-1:0] wr_data_i
);

  localparam int RD_PORTS = 2;
  localparam int OUT_W    = 2 * WORD_W;

  logic bank_q;
  logic stk_q;

  // select inputs take effect one cycle after they change (R6, R7)
  always_ff @(posedge clk) begin
    if (rst) begin
      bank_q <= 1'b0;
      stk_q  <= 1'b0;
    end else begin
      bank_q <= bank_sel_i;
      stk_q  <= stk_sel_i;
    end
  end

  logic [WIDE_W-1:0] regs [NPHYS];
  acc_map_t          wr_map;

  rf_decode #(.CODE_W(CODE_W)) u_wr_dec (
    .bank (bank_q),
    .stk  (stk_q),
    .code (wr_code_i),
    .size (wr_size_i),
    .map  (wr_map)
  );

  rf_store #(.WORD_W(WORD_W), .WIDE_W(WIDE_W)) u_store (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (wr_en_i),
    .map     (wr_map),
    .wr_data (wr_data_i),
    .regs_o  (regs)
  );

  logic [CODE_W-1:0] rd_code [RD_PORTS];
  logic [1:0]        rd_size [RD_PORTS];
  logic [OUT_W-1:0]  rd_data [RD_PORTS];

  assign rd_code[0] = rd0_code_i;
  assign rd_code[1] = rd1_code_i;
  assign rd_size[0] = rd0_size_i;
  assign rd_size[1] = rd1_size_i;

  for (genvar p = 0; p < RD_PORTS; p++) begin : g_rd
    acc_map_t rd_map;

    rf_decode #(.CODE_W(CODE_W)) u_dec (
      .bank (bank_q),
      .stk  (stk_q),
      .code (rd_code[p]),
      .size (rd_size[p]),
      .map  (rd_map)
    );

    rf_read_port #(.WORD_W(WORD_W), .WIDE_W(WIDE_W)) u_rd (
      .clk    (clk),
      .rst    (rst),
      .map    (rd_map),
      .regs   (regs),
      .data_q (rd_data[p])
    );
  end

  assign rd0_data_o = rd_data[0];
  assign rd1_data_o = rd_data[1];

endmodule

// File: rtl/rf_checker.sv
module rf_checker
  import regfile_pkg::*;
#(
  parameter int WORD_W = 16,
  parameter int WIDE_W = 20,
  parameter int CODE_W = 4
) (
  input logic                clk,
  input logic                rst,
  input logic [CODE_W-1:0]   rd0_code_i,
  input logic [1:0]          rd0_size_i,
  input logic [2*WORD_W-1:0] rd0_data_o,
  input logic [CODE_W-1:0]   rd1_size_dummy_unused_guard,
  input logic                wr_en_i,
  input logic [CODE_W-1:0]   wr_code_i,
  input logic [1:0]          wr_size_i,
  input logic [2*WORD_W-1:0] wr_data_i
);

  localparam int OUT_W  = 2 * WORD_W;
  localparam int HALF_W = WORD_W / 2;

  AST_RESET_CLEARS_READ: assert property (@(posedge clk)
    rst |=> rd0_data_o == '0);  // R1

  AST_BYTE_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    (rd0_size_i == SZ_BYTE) |=> rd0_data_o[OUT_W-1:HALF_W] == '0);  // R3

  AST_WORD_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    (rd0_size_i == SZ_WORD && int'(rd0_code_i) <= RC_STK)
      |=> rd0_data_o[OUT_W-1:WORD_W] == '0);  // R2

  AST_WIDE_ZERO_EXTEND: assert property (@(posedge clk) disable iff (rst)
    ((rd0_size_i == SZ_WORD || rd0_size_i == SZ_LONG) &&
     (int'(rd0_code_i) == RC_VTB || int'(rd0_code_i) == RC_PCR))
      |=> rd0_data_o[OUT_W-1:WIDE_W] == '0);  // R5

  AST_BAD_SIZE_READS_ZERO: assert property (@(posedge clk) disable iff (rst)
    (rd0_size_i == 2'd3) |=> rd0_data_o == '0);  // R9

  AST_WRITE_THEN_READ: assert property (@(posedge clk) disable iff (rst)
    (wr_en_i && int'(wr_code_i) == RC_SBR && wr_size_i == SZ_WORD) ##1
    (int'(rd0_code_i) == RC_SBR && rd0_size_i == SZ_WORD)
      |=> rd0_data_o[WORD_W-1:0] == $past(wr_data_i[WORD_W-1:0], 2));  // R8

endmodule

bind banked_regfile rf_checker #(
  .WORD_W(WORD_W), .WIDE_W(WIDE_W), .CODE_W(CODE_W)
) i_chk (
  .clk                         (clk),
  .rst                         (rst),
  .rd0_code_i                  (rd0_code_i),
  .rd0_size_i                  (rd0_size_i),
  .rd0_data_o                  (rd0_data_o),
  .rd1_size_dummy_unused_guard (rd1_code_i),
  .wr_en_i                     (wr_en_i),
  .wr_code_i                   (wr_code_i),
  .wr_size_i                   (wr_size_i),
  .wr_data_i                   (wr_data_i)
);

// File: tb/test_banked_regfile.sv
`timescale 1ns/1ps
module test_banked_regfile;

  localparam int WORD_W = 16;
  localparam int WIDE_W = 20;
  localparam int CODE_W = 4;
  localparam time TCLK  = 20ns;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              bank_sel = 1'b0;
  logic              stk_sel = 1'b0;
  logic [CODE_W-1:0] r0c = '0, r1c = '0, wc = '0;
  logic [1:0]        r0s = 2'd1, r1s = 2'd1, ws = 2'd1;
  logic              wen = 1'b0;
  logic [31:0]       wd = '0;
  logic [31:0]       rd0, rd1;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(TCLK/2) clk = ~clk;

  banked_regfile #(.WORD_W(WORD_W), .WIDE_W(WIDE_W), .CODE_W(CODE_W)) i_banked_regfile (
    .clk(clk), .rst(rst), .bank_sel_i(bank_sel), .stk_sel_i(stk_sel),
    .rd0_code_i(r0c), .rd0_size_i(r0s), .rd0_data_o(rd0),
    .rd1_code_i(r1c), .rd1_size_i(r1s), .rd1_data_o(rd1),
    .wr_en_i(wen), .wr_code_i(wc), .wr_size_i(ws), .wr_data_i(wd)
  );

  // behavioural reference state
  logic [15:0] m_gen [2][7];
  logic [15:0] m_sbr, m_isp, m_usp;
  logic [19:0] m_vtb, m_pcr;
  logic        m_bank, m_stk;

  task automatic model_reset();
    for (int b = 0; b < 2; b++) for (int r = 0; r < 7; r++) m_gen[b][r] = '0;
    m_sbr = '0; m_isp = '0; m_usp = '0; m_vtb = '0; m_pcr = '0;
    m_bank = 1'b0; m_stk = 1'b0;
  endtask

  function automatic logic [31:0] model_read(int code, int size);
    int b = int'(m_bank);
    case (size)
      0: if (code <= 3) begin
           logic [15:0] v = m_gen[b][code / 2];
           return (code % 2 == 1) ? {24'd0, v[15:8]} : {24'd0, v[7:0]};
         end
      1: begin
           if (code <= 6) return {16'd0, m_gen[b][code]};
           if (code == 7) return {16'd0, m_sbr};
           if (code == 8) return {16'd0, (m_stk ? m_usp : m_isp)};
           if (code == 9) return {12'd0, m_vtb};
           if (code == 10) return {12'd0, m_pcr};
         end
      2: begin
           if (code == 0) return {m_gen[b][2], m_gen[b][0]};
           if (code == 1) return {m_gen[b][3], m_gen[b][1]};
           if (code == 4) return {m_gen[b][5], m_gen[b][4]};
           if (code == 9) return {12'd0, m_vtb};
           if (code == 10) return {12'd0, m_pcr};
         end
      default: ;
    endcase
    return 32'd0;
  endfunction

  task automatic model_write(int code, int size, logic [31:0] d);
    int b = int'(m_bank);
    case (size)
      0: if (code <= 3) begin
           if (code % 2 == 1) m_gen[b][code / 2][15:8] = d[7:0];
           else               m_gen[b][code / 2][7:0]  = d[7:0];
         end
      1: begin
           if (code <= 6) m_gen[b][code] = d[15:0];
           else if (code == 7) m_sbr = d[15:0];
           else if (code == 8) begin
             if (m_stk) m_usp = d[15:0]; else m_isp = d[15:0];
           end
           else if (code == 9) m_vtb = d[19:0];
           else if (code == 10) m_pcr = d[19:0];
         end
      2: begin
           if (code == 0) begin m_gen[b][0] = d[15:0]; m_gen[b][2] = d[31:16]; end
           else if (code == 1) begin m_gen[b][1] = d[15:0]; m_gen[b][3] = d[31:16]; end
           else if (code == 4) begin m_gen[b][4] = d[15:0]; m_gen[b][5] = d[31:16]; end
           else if (code == 9) m_vtb = d[19:0];
           else if (code == 10) m_pcr = d[19:0];
         end
      default: ;
    endcase
  endtask

  task automatic check(string tag, string what, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  // one clock: inputs already driven at a falling edge
  task automatic step(string tag);
    logic [31:0] e0, e1;
    e0 = model_read(int'(r0c), int'(r0s));
    e1 = model_read(int'(r1c), int'(r1s));
    @(posedge clk);
    if (wen) model_write(int'(wc), int'(ws), wd);
    m_bank = bank_sel;
    m_stk  = stk_sel;
    @(negedge clk);
    check(tag, "rd0", rd0, e0);
    check(tag, "rd1", rd1, e1);
  endtask

  task automatic op(bit we, int wcode, int wsize, logic [31:0] wdata,
                    int c0, int s0, int c1, int s1, string tag);
    wen = we; wc = CODE_W'(wcode); ws = 2'(wsize); wd = wdata;
    r0c = CODE_W'(c0); r0s = 2'(s0); r1c = CODE_W'(c1); r1s = 2'(s1);
    step(tag);
  endtask

  initial begin
    #(TCLK * 200000);
    fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    model_reset();
    repeat (2) @(posedge clk);
    @(negedge clk);
    check("R1", "rd0 after reset", rd0, 32'd0);
    check("R1", "rd1 after reset", rd1, 32'd0);
    rst = 1'b0;

    // R1: every register reads zero after reset
    for (int c = 0; c <= 10; c += 2) op(0, 0, 1, 0, c, 1, c + 1, 1, "R1");

    // R2: word writes to every code of bank 0
    for (int c = 0; c <= 10; c++) op(1, c, 1, 32'hA5A0_1100 + 32'(c * 32'h0001_0111), 0, 1, 7, 1, "R2");
    for (int c = 0; c <= 10; c += 2) op(0, 0, 1, 0, c, 1, c + 1, 1, "R2");

    // R3: byte writes preserve the other half
    op(1, 1, 0, 32'hFFFF_FF3C, 0, 1, 1, 0, "R3");
    op(1, 2, 0, 32'h0000_00C7, 0, 1, 1, 1, "R3");
    op(0, 0, 0, 0, 0, 0, 1, 0, "R3");
    op(0, 0, 0, 0, 2, 0, 3, 0, "R3");
    op(0, 0, 0, 0, 0, 1, 1, 1, "R3");

    // R4: long pair writes and reads
    op(1, 0, 2, 32'h1357_2468, 0, 2, 1, 2, "R4");
    op(1, 1, 2, 32'h9BDF_8ACE, 0, 2, 2, 1, "R4");
    op(1, 4, 2, 32'hCAFE_F00D, 1, 2, 4, 2, "R4");
    op(0, 0, 0, 0, 4, 1, 5, 1, "R4");
    op(0, 0, 0, 0, 3, 1, 4, 2, "R4");

    // R5: wide registers through word and long size
    op(1, 9, 2, 32'hFFFA_BCDE, 9, 1, 10, 2, "R5");
    op(1, 10, 1, 32'hFFF1_2345, 9, 2, 10, 1, "R5");
    op(0, 0, 0, 0, 9, 1, 10, 2, "R5");

    // R8: same-cycle read returns old, next cycle the new
    op(1, 7, 1, 32'h0000_7E57, 7, 1, 7, 1, "R8");
    op(1, 0, 2, 32'h4444_3333, 0, 2, 2, 1, "R8");
    op(0, 0, 0, 0, 7, 1, 0, 2, "R8");

    // R6: bank change applies one cycle later, no copying
    bank_sel = 1'b1;
    op(0, 0, 0, 0, 0, 1, 4, 2, "R6");
    op(0, 0, 0, 0, 0, 1, 6, 1, "R6");
    op(1, 0, 1, 32'h0000_B1B1, 0, 1, 7, 1, "R6");
    op(1, 6, 1, 32'h0000_F1F1, 0, 1, 6, 1, "R6");
    bank_sel = 1'b0;
    op(0, 0, 0, 0, 0, 1, 6, 1, "R6");
    op(0, 0, 0, 0, 0, 1, 6, 1, "R6");

    // R7: stack pointer selection
    op(1, 8, 1, 32'h0000_1A1A, 8, 1, 8, 1, "R7");
    stk_sel = 1'b1;
    op(1, 8, 1, 32'h0000_2B2B, 8, 1, 8, 1, "R7");
    op(1, 8, 1, 32'h0000_3C3C, 8, 1, 8, 1, "R7");
    stk_sel = 1'b0;
    op(0, 0, 0, 0, 8, 1, 8, 1, "R7");
    op(0, 0, 0, 0, 8, 1, 8, 1, "R7");

    // R9: invalid reads give zero, invalid writes change nothing
    op(1, 0, 3, 32'hDEAD_BEEF, 0, 3, 5, 0, "R9");
    op(1, 5, 0, 32'hDEAD_BEEF, 0, 1, 5, 1, "R9");
    op(1, 2, 2, 32'hDEAD_BEEF, 2, 2, 11, 1, "R9");
    op(1, 12, 1, 32'hDEAD_BEEF, 0, 2, 15, 2, "R9");
    op(0, 0, 0, 0, 2, 1, 3, 1, "R9");

    // R10: random traffic on both ports with select toggling
    for (int i = 0; i < 2000; i++) begin
      if ($urandom_range(0, 9) == 0) bank_sel = ~bank_sel;
      if ($urandom_range(0, 9) == 0) stk_sel  = ~stk_sel;
      op($urandom_range(0, 1) == 1, $urandom_range(0, 15), $urandom_range(0, 3), $urandom,
         $urandom_range(0, 15), $urandom_range(0, 3),
         $urandom_range(0, 15), $urandom_range(0, 3), "R10");
    end

    // R1: reset clears again after traffic
    rst = 1'b1;
    @(posedge clk);
    model_reset();
    @(negedge clk);
    rst = 1'b0;
    for (int c = 0; c <= 10; c += 2) op(0, 0, 1, 0, c, 1, c + 1, 1, "R1");

    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

endmodule